// File: doc/BRIEF.md
# Auto Wake-Up Interval Timer

This block wakes a halted device after a programmable delay without keeping the main oscillator running. A free-running auxiliary RC clock drives a fixed power-of-two divider followed by an 8-bit prescaler. The chain counts only while the device is halted, the wake-up feature is enabled and the main-clock periodic interrupt is disabled. When the programmed interval has elapsed, an event crosses into the main clock domain, sets a wake-up flag and raises the wake-up interrupt. The chain keeps running while the device stays halted, so the event repeats once per interval.

Software controls the block through a small synchronous register bus. Reading the control/status register returns the flag and clears both the flag and the interrupt. A calibration mode sends the raw RC clock to an input-capture output while the device is running. Software can then measure the RC frequency against the main clock and choose a prescaler value that gives the wanted delay.

Top module: `awu_timer`

## Requirements
- R1: After reset both registers read 0x00, `wake_irq` is low and `cap_out` is low.
- R2: Address 0 is control/status. Bit 0 is the wake enable, bit 1 is the calibration enable and bit 7 is the read-only wake flag. All other bits read as 0. Address 1 is the 8-bit prescaler, which reads back as written. Read data appears on `bus_rdata` one clock after the access.
- R3: Once armed, the first wake flag rises exactly FDIV*P RC rising edges after arming completes. FDIV is 2**DIV_W (64 by default) and P is the prescaler value. Arming needs 2 RC rising edges of synchronisation, so the bench sees FDIV*P+2 edges counted from the rise of `halt`.
- R4: A prescaler value of 0 gives the same interval as a value of 1.
- R5: While the block stays armed, wake events repeat every FDIV*P RC edges (with P=1 when the register holds 0). If the flag was cleared in between, it sets again.
- R6: A read of address 0 returns the flag in bit 7, and the flag and `wake_irq` are low on the next clock. A read of address 1 leaves the flag unchanged.
- R7: No wake event occurs unless `halt`, the wake enable and `tick_irq_off` are all high.
- R8: Leaving halt resets the divider and prescaler. A later halt entry waits a full interval again.
- R9: The wake flag stays set after `halt` falls until address 0 is read.
- R10: While the calibration enable is set and `halt` is low, `cap_out` follows `rc_clk`. Otherwise `cap_out` is low.
- R11: Writes to bit 7 of address 0 have no effect on the flag. Writing 1 does not set it and writing 0 does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rc_clk | input | 1 | Auxiliary RC clock |
| halt | input | 1 | Device is in halt |
| tick_irq_off | input | 1 | Main-clock periodic interrupt is disabled (arming condition) |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| wake_irq | output | 1 | Wake-up interrupt request (level, equals the flag) |
| cap_out | output | 1 | RC clock to input capture in calibration mode |

## Verification
The hardest case to reach from the ports is the exact interval length. The count lives entirely in the RC domain behind two synchronisers, so it shows up only as a flag in the other clock domain. The bench offsets the two clocks so that their edges never coincide. It counts RC edges from the rise of `halt` to the first sampled flag. It then repeats the measurement for the next event while still halted. This pins both the first interval and the period to an exact edge count. The sweep uses a small fixed divider and covers prescaler values 0 to 20 and the upper end of the range. A short halt cut off partway through an interval, followed by a re-entry, shows that the chain restarts from zero.

// File: rtl/awu_pkg.sv
package awu_pkg;

  localparam int unsigned PRESC_W = 8;

  typedef struct packed {
    logic wake_en;
    logic cal_en;
  } awu_ctrl_t;

  // prescaler value as used by the chain: zero behaves as one
  function automatic logic [PRESC_W-1:0] eff_presc(input logic [PRESC_W-1:0] p);
    return (p == '0) ? PRESC_W'(1) : p;
  endfunction

  // RC edges in one wake interval
  function automatic int unsigned interval_len(input int unsigned div_w,
                                               input logic [PRESC_W-1:0] p);
    return (32'd1 << div_w) * int'(eff_presc(p));
  endfunction

endpackage

// File: rtl/awu_sync.sv
module awu_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/awu_rc_chain.sv
module awu_rc_chain
  import awu_pkg::*;
#(
  parameter int unsigned DIV_W = 6
) (
  input  logic               rc_clk,
  input  logic               rst_n,
  input  logic               arm_req,
  input  logic [PRESC_W-1:0] presc_q,
  output logic               arm_rc,
  output logic [DIV_W-1:0]   div_cnt,
  output logic [PRESC_W-1:0] pre_cnt,
  output logic               wrap_evt,
  output logic               tick_tgl
);
  logic [PRESC_W-1:0] presc_eff;
  logic               div_last;
  logic               pre_last;

  awu_sync #(.W(1)) u_arm_sync (
    .clk  (rc_clk),
    .rst_n(rst_n),
    .d    (arm_req),
    .q    (arm_rc)
  );

  assign presc_eff = eff_presc(presc_q);
  assign div_last  = &div_cnt;
  assign pre_last  = (pre_cnt >= presc_eff - PRESC_W'(1));
  assign wrap_evt  = arm_rc && div_last && pre_last;

  always_ff @(posedge rc_clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt  <= '0;
      pre_cnt  <= '0;
      tick_tgl <= 1'b0;
    end else if (!arm_rc) begin
      div_cnt <= '0;
      pre_cnt <= '0;
    end else begin
      div_cnt <= div_cnt + DIV_W'(1);
      if (div_last) begin
        pre_cnt <= pre_last ? '0 : pre_cnt + PRESC_W'(1);
      end
      if (wrap_evt) begin
        tick_tgl <= ~tick_tgl;
      end
    end
  end
endmodule

// File: rtl/awu_regs.sv
module awu_regs
  import awu_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic               bus_addr,
  input  logic [7:0]         bus_wdata,
  input  logic               set_evt,
  output logic [7:0]         bus_rdata,
  output awu_ctrl_t          ctrl_q,
  output logic [PRESC_W-1:0] presc_q,
  output logic               flag_q,
  output logic               rd_stat
);
  logic wr_ctrl;
  logic wr_presc;

  assign rd_stat  = bus_sel && !bus_wr && !bus_addr;
  assign wr_ctrl  = bus_sel &&  bus_wr && !bus_addr;
  assign wr_presc = bus_sel &&  bus_wr &&  bus_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      presc_q   <= '0;
      flag_q    <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (wr_ctrl) begin
        ctrl_q.wake_en <= bus_wdata[0];
        ctrl_q.cal_en  <= bus_wdata[1];
      end
      if (wr_presc) begin
        presc_q <= bus_wdata;
      end
      // a new event wins over a clearing read
      if (set_evt) begin
        flag_q <= 1'b1;
      end else if (rd_stat) begin
        flag_q <= 1'b0;
      end
      if (bus_sel && !bus_wr) begin
        bus_rdata <= bus_addr ? presc_q
                              : {flag_q, 5'b0, ctrl_q.cal_en, ctrl_q.wake_en};
      end
    end
  end
endmodule

// File: rtl/awu_timer.sv
module awu_timer
  import awu_pkg::*;
#(
  parameter int unsigned DIV_W = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rc_clk,
  input  logic       halt,
  input  logic       tick_irq_off,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wake_irq,
  output logic       cap_out
);
  awu_ctrl_t          ctrl_q;
  logic [PRESC_W-1:0] presc_q;
  logic               flag_q;
  logic               rd_stat;
  logic               arm_req;
  logic               arm_rc;
  logic [DIV_W-1:0]   div_cnt;
  logic [PRESC_W-1:0] pre_cnt;
  logic               wrap_evt;
  logic               tick_tgl;
  logic               tgl_s2;
  logic               tgl_s3;
  logic               set_evt;

  assign arm_req = halt && ctrl_q.wake_en && tick_irq_off;

  awu_rc_chain #(.DIV_W(DIV_W)) u_chain (
    .rc_clk  (rc_clk),
    .rst_n   (rst_n),
    .arm_req (arm_req),
    .presc_q (presc_q),
    .arm_rc  (arm_rc),
    .div_cnt (div_cnt),
    .pre_cnt (pre_cnt),
    .wrap_evt(wrap_evt),
    .tick_tgl(tick_tgl)
  );

  awu_sync #(.W(1)) u_tgl_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (tick_tgl),
    .q    (tgl_s2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgl_s3 <= 1'b0;
    else        tgl_s3 <= tgl_s2;
  end

  assign set_evt = tgl_s2 ^ tgl_s3;

  awu_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .set_evt  (set_evt),
    .bus_rdata(bus_rdata),
    .ctrl_q   (ctrl_q),
    .presc_q  (presc_q),
    .flag_q   (flag_q),
    .rd_stat  (rd_stat)
  );

  assign wake_irq = flag_q;
  assign cap_out  = rc_clk && ctrl_q.cal_en && !halt;
endmodule

// File: rtl/awu_timer_chk.sv
module awu_timer_chk
  import awu_pkg::*;
#(
  parameter int unsigned DIV_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rc_clk,
  input logic               halt,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic               bus_addr,
  input logic [7:0]         bus_wdata,
  input logic [PRESC_W-1:0] presc_q,
  input logic               rd_stat,
  input logic               set_evt,
  input logic               wake_irq,
  input logic               cap_out,
  input logic               arm_rc,
  input logic [DIV_W-1:0]   div_cnt,
  input logic [PRESC_W-1:0] pre_cnt,
  input logic               tick_tgl
);
  assert_rdclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !set_evt) |=> !wake_irq);

  assert_no_spurious_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wake_irq && !set_evt) |=> !wake_irq);

  assert_presc_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr) |=> (presc_q == $past(bus_wdata)));

  assert_cap_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> !cap_out);

  assert_idle_zero_R8: assert property (@(posedge rc_clk) disable iff (!rst_n)
    !arm_rc |=> (div_cnt == '0 && pre_cnt == '0));

  assert_tick_at_wrap_R3: assert property (@(posedge rc_clk) disable iff (!rst_n)
    !(arm_rc && (&div_cnt)) |=> $stable(tick_tgl));
endmodule

bind awu_timer awu_timer_chk #(.DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rc_clk   (rc_clk),
  .halt     (halt),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .presc_q  (presc_q),
  .rd_stat  (rd_stat),
  .set_evt  (set_evt),
  .wake_irq (wake_irq),
  .cap_out  (cap_out),
  .arm_rc   (arm_rc),
  .div_cnt  (div_cnt),
  .pre_cnt  (pre_cnt),
  .tick_tgl (tick_tgl)
);

// File: tb/awu_timer_tb.sv
module awu_timer_tb;
  localparam int unsigned DW   = 3;
  localparam int unsigned FDIV = 1 << DW;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rc_clk = 1'b0;
  logic       halt = 1'b0;
  logic       tick_irq_off = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic       bus_addr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       wake_irq;
  logic       cap_out;

  int n_chk = 0;
  int n_fail = 0;
  int rc_edges = 0;
  int cyc = 0;

  awu_timer #(.DIV_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .rc_clk(rc_clk), .halt(halt),
    .tick_irq_off(tick_irq_off), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wake_irq(wake_irq), .cap_out(cap_out)
  );

  always #4 clk = ~clk;                       // 125 MHz
  initial begin #3; forever begin rc_clk = ~rc_clk; #20; end end
  always @(posedge rc_clk) rc_edges <= rc_edges + 1;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  function automatic int eff(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  // waits at main negedges for wake_irq; returns rc_edges at detection, -1 on timeout
  task automatic wait_irq(input int max_cyc, output int edge_at);
    edge_at = -1;
    for (int i = 0; i < max_cyc; i++) begin
      @(negedge clk);
      if (wake_irq) begin edge_at = rc_edges; break; end
    end
  endtask

  task automatic wait_rc(input int n);
    for (int i = 0; i < n; i++) @(posedge rc_clk);
    @(negedge clk);
  endtask

  task automatic run_interval(input int p);
    int e0, e1, e2, n;
    logic [7:0] rd;
    n = FDIV * eff(p);
    bus_write(1'b1, 8'(p));
    bus_write(1'b0, 8'h01);
    @(negedge clk);
    halt = 1'b1;
    e0 = rc_edges;
    wait_irq(n * 6 + 100, e1);
    if (p == 0) check("R4 first interval p=0", e1 - e0, n + 2);
    else        check("R3 first interval", e1 - e0, n + 2);
    bus_read(1'b0, rd);
    check("R6 flag read bit7", int'(rd[7]), 1);
    @(negedge clk);
    check("R6 irq cleared", int'(wake_irq), 0);
    wait_irq(n * 6 + 100, e2);
    check("R5 repeat period", e2 - e1, n);
    @(negedge clk);
    halt = 1'b0;
    wait_rc(3);
    check("R9 flag held after halt", int'(wake_irq), 1);
    bus_read(1'b0, rd);
    wait_rc(3);
  endtask

  initial begin
    logic [7:0] rd;
    int e0, e1, mis;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", int'(wake_irq), 0);
    check("R1 cap_out", int'(cap_out), 0);
    bus_read(1'b0, rd); check("R1 status reg", int'(rd), 0);
    bus_read(1'b1, rd); check("R1 presc reg", int'(rd), 0);

    // R2 register readback
    bus_write(1'b1, 8'hA5); bus_read(1'b1, rd); check("R2 presc readback", int'(rd), 8'hA5);
    bus_write(1'b0, 8'hFF); bus_read(1'b0, rd); check("R2 R11 status readback", int'(rd), 8'h03);
    bus_write(1'b0, 8'h80); bus_read(1'b0, rd); check("R11 write bit7 ignored", int'(rd), 8'h00);
    check("R11 irq after bit7 write", int'(wake_irq), 0);

    // R7 no arming conditions
    tick_irq_off = 1'b1;
    bus_write(1'b1, 8'd1);
    bus_write(1'b0, 8'h00);
    @(negedge clk); halt = 1'b1;
    wait_rc(FDIV * 3);
    check("R7 disabled no wake", int'(wake_irq), 0);
    @(negedge clk); halt = 1'b0;
    bus_write(1'b0, 8'h01);
    tick_irq_off = 1'b0;
    @(negedge clk); halt = 1'b1;
    wait_rc(FDIV * 3);
    check("R7 tick irq on no wake", int'(wake_irq), 0);
    @(negedge clk); halt = 1'b0;
    tick_irq_off = 1'b1;
    wait_rc(3);

    // R3 R4 R5 R6 R9 prescaler sweep
    for (int p = 0; p <= 20; p++) run_interval(p);
    run_interval(100);
    run_interval(254);
    run_interval(255);

    // R8 partial halt then full restart
    bus_write(1'b1, 8'd6);
    bus_write(1'b0, 8'h01);
    @(negedge clk); halt = 1'b1;
    wait_rc(FDIV * 4);
    check("R8 no wake before interval", int'(wake_irq), 0);
    @(negedge clk); halt = 1'b0;
    wait_rc(4);
    @(negedge clk); halt = 1'b1;
    e0 = rc_edges;
    wait_irq(FDIV * 6 * 6 + 100, e1);
    check("R8 full interval after re-entry", e1 - e0, FDIV * 6 + 2);
    @(negedge clk); halt = 1'b0;
    bus_read(1'b1, rd);
    check("R6 presc read keeps flag", int'(wake_irq), 1);
    bus_write(1'b0, 8'h01);
    check("R11 write 0 bit7 keeps flag", int'(wake_irq), 1);
    bus_read(1'b0, rd);
    @(negedge clk);
    check("R6 cleared by status read", int'(wake_irq), 0);

    // R10 calibration mux
    bus_write(1'b0, 8'h02);
    mis = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (cap_out !== rc_clk) mis++; end
    check("R10 cap follows rc", mis, 0);
    @(negedge clk); halt = 1'b1;
    mis = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (cap_out !== 1'b0) mis++; end
    check("R10 cap low in halt", mis, 0);
    @(negedge clk); halt = 1'b0;
    bus_write(1'b0, 8'h00);
    mis = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (cap_out !== 1'b0) mis++; end
    check("R10 cap low when off", mis, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule